// File: doc/BRIEF.md
# Open-Row DRAM Controller with Refresh

This block connects a simple request port (address, write flag, write data, valid/ready) to a small DRAM array that sits behind a narrow address bus. Each request address is split into a row index and a column index, and both are sent over the same few address pins, one after the other. An activate strobe carrying the row index copies the whole row into the array's row buffer. A column strobe carrying the column index then reads one supercell from the buffer or writes one into it. A behavioural array with its row buffer is part of the block, and its strobes are brought out as outputs.

The controller leaves the last row open. A request to the open row needs only a column strobe. A request to another row first writes the buffer back to the cell array (precharge), then activates the new row. A timer asks for a refresh every `REF_INTERVAL` cycles. The controller serves that request only between accesses. It closes any open row, then activates and precharges the next row in a rotating sequence, so every row is restored once per `ROWS * REF_INTERVAL` cycles. For a wide word, `CHIPS` byte-wide arrays share one address. Lane k holds data bits 8k+7 down to 8k.

Top module: `dramc_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rd_valid` is 0, no strobe is active, and all cells read as zero.
- R2: The request address is {row, column}, with the row in the upper `$clog2(ROWS)` bits. During an activate the controller drives the row index on `mem_addr`, and during a column strobe it drives the column index.
- R3: When no row is open, an accepted request produces an activate in the next cycle and a column strobe in the cycle after that. A read's data appears 3 cycles after acceptance.
- R4: A request to the open row produces only a column strobe, with no activate and no precharge. A read's data appears 2 cycles after acceptance.
- R5: A request to a row other than the open one produces a precharge, an activate and a column strobe in three consecutive cycles. A read's data appears 4 cycles after acceptance.
- R6: A write updates the row buffer. The value survives the row being closed and is read back after another row has been opened in between.
- R7: Each read produces exactly one single-cycle `rd_valid` pulse, in the cycle after its column strobe, carrying the data. A write produces no pulse.
- R8: Refresh activates rows in the rotating order 0, 1, ..., ROWS-1. While no requests arrive, successive refresh activates are exactly `REF_INTERVAL` cycles apart.
- R9: A refresh never falls between a request's acceptance and its column strobe. `req_ready` is low during refresh, and refresh leaves no row open.
- R10: With `CHIPS` lanes, the full `8*CHIPS`-bit word is written and read back intact, each lane at the shared (row, column).
- R11: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays low until that access has issued its column strobe, so a request held valid is served once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | {row, column} address |
| req_wdata | input | DW | Write data, DW = W*CHIPS |
| rd_valid | output | 1 | One-cycle read-data pulse |
| rd_data | output | DW | Read data |
| mem_act | output | 1 | Activate strobe (row into buffer) |
| mem_pre | output | 1 | Precharge strobe (buffer back to array) |
| mem_col | output | 1 | Column strobe |
| mem_we | output | 1 | Column strobe is a write |
| mem_refresh | output | 1 | Current strobe belongs to a refresh |
| mem_addr | output | AW | Multiplexed row/column index |

## Verification
The assertions assume that a requester holds its address, write flag and data steady while `req_valid` is high and `req_ready` is low. They also assume the timer interval is longer than the longest access, so that one refresh can finish before the next is requested. The bench changes its inputs only on falling edges. It keeps each request unchanged until it sees the acceptance edge and then drops `req_valid` at once. It uses an interval of 300 cycles, far above the four-cycle access, so the latency tests with their exact strobe counts finish before the first refresh. Refresh interplay is then tested separately, with a back-to-back request stream.

// File: rtl/dramc_pkg.sv
package dramc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_RCLOSE,
    ST_RACT,
    ST_RPRE
  } dramc_state_e;
endpackage

// File: rtl/dramc_array.sv
module dramc_array #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int W    = 8,
  parameter int AW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic          pre,
  input  logic          col,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int RB = $clog2(ROWS);
  localparam int CB = $clog2(COLS);

  logic [W-1:0]  cells [ROWS][COLS];
  logic [W-1:0]  rbuf  [COLS];
  logic [RB-1:0] buf_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_row <= '0;
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) cells[r][c] <= '0;
      for (int c = 0; c < COLS; c++) rbuf[c] <= '0;
    end else begin
      if (act) begin
        buf_row <= addr[RB-1:0];
        for (int c = 0; c < COLS; c++) rbuf[c] <= cells[addr[RB-1:0]][c];
      end
      if (pre)
        for (int c = 0; c < COLS; c++) cells[buf_row][c] <= rbuf[c];
      if (col && we) rbuf[addr[CB-1:0]] <= wdata;
    end
  end

  assign rdata = rbuf[addr[CB-1:0]];
endmodule

// File: rtl/dramc_refresh_timer.sv
module dramc_refresh_timer #(
  parameter int ROWS         = 4,
  parameter int REF_INTERVAL = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_done,
  output logic                    ref_pend,
  output logic [$clog2(ROWS)-1:0] ref_row
);
  localparam int CW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_INTERVAL - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)          ref_pend <= 1'b1;
      else if (ref_done) ref_pend <= 1'b0;
      if (ref_done) ref_row <= ref_row + 1'b1;
    end
  end
endmodule

// File: rtl/dramc_ctrl.sv
module dramc_ctrl
  import dramc_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8,
  parameter int AW   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [$clog2(ROWS)+$clog2(COLS)-1:0] req_addr,
  input  logic [DW-1:0]           req_wdata,
  output logic                    rd_valid,
  output logic [DW-1:0]           rd_data,
  input  logic                    ref_pend,
  input  logic [$clog2(ROWS)-1:0] ref_row,
  output logic                    ref_done,
  output logic                    mem_act,
  output logic                    mem_pre,
  output logic                    mem_col,
  output logic                    mem_we,
  output logic                    mem_refresh,
  output logic [AW-1:0]           mem_addr,
  output logic [DW-1:0]           mem_wdata,
  input  logic [DW-1:0]           mem_rdata
);
  localparam int RB     = $clog2(ROWS);
  localparam int CB     = $clog2(COLS);
  localparam int ADDR_W = RB + CB;

  function automatic logic [RB-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:CB];
  endfunction

  function automatic logic [CB-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[CB-1:0];
  endfunction

  dramc_state_e  state;
  logic          row_open;
  logic [RB-1:0] open_row;
  logic [RB-1:0] lat_row;
  logic [CB-1:0] lat_col;
  logic          lat_we;
  logic [DW-1:0] lat_wdata;
  logic          accept;
  logic          row_hit;

  assign req_ready = (state == ST_IDLE) && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign row_hit   = row_open && (open_row == row_of(req_addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      row_open  <= 1'b0;
      open_row  <= '0;
      lat_row   <= '0;
      lat_col   <= '0;
      lat_we    <= 1'b0;
      lat_wdata <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            state <= row_open ? ST_RCLOSE : ST_RACT;
          end else if (accept) begin
            lat_row   <= row_of(req_addr);
            lat_col   <= col_of(req_addr);
            lat_we    <= req_write;
            lat_wdata <= req_wdata;
            if (row_hit)       state <= ST_COL;
            else if (row_open) state <= ST_PRE;
            else               state <= ST_ACT;
          end
        end
        ST_PRE: begin
          row_open <= 1'b0;
          state    <= ST_ACT;
        end
        ST_ACT: begin
          row_open <= 1'b1;
          open_row <= lat_row;
          state    <= ST_COL;
        end
        ST_COL: begin
          rd_valid <= !lat_we;
          if (!lat_we) rd_data <= mem_rdata;
          state <= ST_IDLE;
        end
        ST_RCLOSE: begin
          row_open <= 1'b0;
          state    <= ST_RACT;
        end
        ST_RACT: state <= ST_RPRE;
        ST_RPRE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_act     = (state == ST_ACT) || (state == ST_RACT);
  assign mem_pre     = (state == ST_PRE) || (state == ST_RCLOSE) || (state == ST_RPRE);
  assign mem_col     = (state == ST_COL);
  assign mem_we      = mem_col && lat_we;
  assign mem_refresh = (state == ST_RCLOSE) || (state == ST_RACT) || (state == ST_RPRE);
  assign ref_done    = (state == ST_RPRE);
  assign mem_wdata   = lat_wdata;

  always_comb begin
    mem_addr = '0;
    if (state == ST_ACT)       mem_addr = AW'(lat_row);
    else if (state == ST_RACT) mem_addr = AW'(ref_row);
    else if (state == ST_COL)  mem_addr = AW'(lat_col);
  end
endmodule

// File: rtl/dramc_top.sv
module dramc_top #(
  parameter int ROWS         = 4,
  parameter int COLS         = 4,
  parameter int W            = 8,
  parameter int CHIPS        = 1,
  parameter int REF_INTERVAL = 1000,
  localparam int RB          = $clog2(ROWS),
  localparam int CB          = $clog2(COLS),
  localparam int ADDR_W      = RB + CB,
  localparam int AW          = (RB > CB) ? RB : CB,
  localparam int DW          = W * CHIPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic              mem_act,
  output logic              mem_pre,
  output logic              mem_col,
  output logic              mem_we,
  output logic              mem_refresh,
  output logic [AW-1:0]     mem_addr
);
  logic          ref_pend;
  logic          ref_done;
  logic [RB-1:0] ref_row;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  dramc_refresh_timer #(.ROWS(ROWS), .REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_done(ref_done),
    .ref_pend(ref_pend), .ref_row(ref_row)
  );

  dramc_ctrl #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_pend(ref_pend), .ref_row(ref_row), .ref_done(ref_done),
    .mem_act(mem_act), .mem_pre(mem_pre), .mem_col(mem_col), .mem_we(mem_we),
    .mem_refresh(mem_refresh), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  for (genvar k = 0; k < CHIPS; k++) begin : g_lane
    dramc_array #(.ROWS(ROWS), .COLS(COLS), .W(W), .AW(AW)) u_array (
      .clk(clk), .rst_n(rst_n),
      .act(mem_act), .pre(mem_pre), .col(mem_col), .we(mem_we),
      .addr(mem_addr),
      .wdata(mem_wdata[W*k +: W]),
      .rdata(mem_rdata[W*k +: W])
    );
  end
endmodule

// File: rtl/dramc_checker.sv
module dramc_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rd_valid,
  input logic mem_act,
  input logic mem_pre,
  input logic mem_col,
  input logic mem_we,
  input logic mem_refresh
);
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_act, mem_pre, mem_col}));

  a_r3_act_then_col: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_act && !mem_refresh) |=> mem_col);

  a_r5_pre_then_act: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_pre && !mem_refresh) |=> (mem_act && !mem_refresh));

  a_r7_pulse_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mem_col && !mem_we));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r9_no_ready_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    mem_refresh |-> !req_ready);

  a_r9_refresh_ends_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_refresh && mem_act) |=> (mem_refresh && mem_pre));

  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind dramc_top dramc_checker u_dramc_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .mem_act(mem_act), .mem_pre(mem_pre),
  .mem_col(mem_col), .mem_we(mem_we), .mem_refresh(mem_refresh)
);

// File: tb/test_dramc_top.sv
module test_dramc_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4, COLS = 4, W = 8, CHIPS = 2, INTERVAL = 300;
  localparam int ADDR_W = 4, AW = 2, DW = W * CHIPS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, mem_act, mem_pre, mem_col, mem_we, mem_refresh;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0;
  int cyc = 0, n_act = 0, n_pre = 0, n_col = 0, n_ref = 0;
  int ref_t [64];
  int ref_r [64];
  logic [AW-1:0] last_act_addr, last_col_addr;
  logic last_col_we;
  logic [DW-1:0] shadow [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  dramc_top #(.ROWS(ROWS), .COLS(COLS), .W(W), .CHIPS(CHIPS), .REF_INTERVAL(INTERVAL)) i_dramc_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_act(mem_act), .mem_pre(mem_pre),
    .mem_col(mem_col), .mem_we(mem_we), .mem_refresh(mem_refresh), .mem_addr(mem_addr)
  );

  // Strobe monitor: counts what was present during the cycle ending at each edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (mem_act) begin
        n_act <= n_act + 1;
        last_act_addr <= mem_addr;
        if (mem_refresh) begin
          if (n_ref < 64) begin
            ref_t[n_ref] <= cyc;
            ref_r[n_ref] <= int'(mem_addr);
          end
          n_ref <= n_ref + 1;
        end
      end
      if (mem_pre) n_pre <= n_pre + 1;
      if (mem_col) begin
        n_col <= n_col + 1;
        last_col_addr <= mem_addr;
        last_col_we <= mem_we;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One access; exp_n = negedges from acceptance to the column strobe being counted (0 = skip timing)
  task automatic access(input bit we, input logic [ADDR_W-1:0] a, input logic [DW-1:0] wd,
                        input int exp_n, input int exp_pre, input int exp_act,
                        input bit chk_data, input logic [DW-1:0] exp_d, input string req);
    int s_act, s_pre, s_col, s_ref, n;
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = wd;
    forever begin
      @(posedge clk);
      if (req_ready) break;
    end
    @(negedge clk);
    req_valid = 1'b0;
    s_act = n_act; s_pre = n_pre; s_col = n_col; s_ref = n_ref;
    check(req_ready == 1'b0, "R11", "ready after accept", req_ready, 0);
    n = 1;
    while (n_col == s_col && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n_col == s_col + 1, "R11", "column strobes", n_col - s_col, 1);
    check(n_ref == s_ref, "R9", "refresh inside access", n_ref - s_ref, 0);
    if (exp_n != 0) begin
      check(n == exp_n, req, "latency", n, exp_n);
      check(n_pre - s_pre == exp_pre, req, "precharges", n_pre - s_pre, exp_pre);
      check(n_act - s_act == exp_act, req, "activates", n_act - s_act, exp_act);
      if (exp_act != 0)
        check(last_act_addr == a[3:2], "R2", "row on address pins", last_act_addr, a[3:2]);
      check(last_col_addr == a[1:0], "R2", "column on address pins", last_col_addr, a[1:0]);
      check(last_col_we == we, "R2", "column write flag", last_col_we, we);
    end
    check(rd_valid == !we, "R7", "rd_valid at completion", rd_valid, !we);
    if (!we && chk_data) check(rd_data == exp_d, req, "read data", rd_data, exp_d);
    @(negedge clk);
    check(rd_valid == 1'b0, "R7", "rd_valid pulse width", rd_valid, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
    check({mem_act, mem_pre, mem_col} == 3'b000, "R1", "strobes after reset",
          {mem_act, mem_pre, mem_col}, 0);
  endtask

  task automatic t_closed_row;
    access(1'b1, 4'h6, 16'hA55A, 3, 0, 1, 1'b0, '0, "R3");
    access(1'b0, 4'h6, '0, 2, 0, 0, 1'b1, 16'hA55A, "R4");
  endtask

  task automatic t_open_hit;
    access(1'b1, 4'h4, 16'h1234, 2, 0, 0, 1'b0, '0, "R4");
    access(1'b0, 4'h4, '0, 2, 0, 0, 1'b1, 16'h1234, "R4");
    access(1'b0, 4'h5, '0, 2, 0, 0, 1'b1, 16'h0000, "R1");
  endtask

  task automatic t_row_miss;
    access(1'b0, 4'hB, '0, 4, 1, 1, 1'b1, 16'h0000, "R5");
    access(1'b0, 4'h6, '0, 4, 1, 1, 1'b1, 16'hA55A, "R6");
    access(1'b0, 4'h4, '0, 2, 0, 0, 1'b1, 16'h1234, "R6");
  endtask

  task automatic t_lanes;
    access(1'b1, 4'hC, 16'hBE0F, 4, 1, 1, 1'b0, '0, "R10");
    access(1'b1, 4'h1, 16'h00FF, 4, 1, 1, 1'b0, '0, "R10");
    access(1'b0, 4'hC, '0, 4, 1, 1, 1'b1, 16'hBE0F, "R10");
    access(1'b0, 4'h1, '0, 4, 1, 1, 1'b1, 16'h00FF, "R10");
  endtask

  task automatic t_refresh;
    int base = n_ref;
    while (n_ref < base + 4) @(negedge clk);
    for (int i = 1; i < 4; i++)
      check(ref_r[base+i] == (ref_r[base+i-1] + 1) % ROWS, "R8", "refresh row order",
            ref_r[base+i], (ref_r[base+i-1] + 1) % ROWS);
    for (int i = 2; i < 4; i++)
      check(ref_t[base+i] - ref_t[base+i-1] == INTERVAL, "R8", "refresh spacing",
            ref_t[base+i] - ref_t[base+i-1], INTERVAL);
    repeat (3) @(negedge clk);
    access(1'b0, 4'hC, '0, 3, 0, 1, 1'b1, 16'hBE0F, "R9");
  endtask

  task automatic t_flood;
    int base = n_ref;
    for (int a = 0; a < 16; a++) begin
      shadow[a] = 16'h5A00 ^ DW'(a * 16'h0111);
      access(1'b1, ADDR_W'(a), shadow[a], 0, 0, 0, 1'b0, '0, "R9");
    end
    for (int p = 0; p < 40 && n_ref < base + 2; p++)
      for (int a = 0; a < 16; a++) begin
        int q = (a * 5 + p) % 16;
        access(1'b0, ADDR_W'(q), '0, 0, 0, 0, 1'b1, shadow[q], "R9");
      end
    check(n_ref >= base + 2, "R9", "refresh served under load", n_ref - base, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_closed_row();
    t_open_hit();
    t_row_miss();
    t_lanes();
    t_refresh();
    t_flood();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule